// File: doc/BRIEF.md
# PIPE Power State and Receiver-Detect Controller

This block sits on the PHY side of a PIPE link and handles its control handshake. The link controller asks for one of four power states through a 2-bit code. The block moves to the requested state after a latency set by a parameter for each state. It then reports completion with a single-cycle status strobe. The same strobe also closes a far-end receiver detection. The controller starts a detection when asked in the right state. The detection result appears on the 3-bit receive status field during the strobe cycle.

After reset the block comes up in P2 and holds the status output high. It drops the strobe once a fixed start-up count has elapsed, which stands in for the clock becoming stable. Only one operation runs at a time, and one counter times all of them. The analog sensing of a far-end termination is modelled by a plain input that the block samples when detection completes. The block also gates the transmitter's electrical-idle control and its loopback request according to the current power state.

Top module: `pipe_pwr_ctrl`

## Requirements
- R1: While reset is low, and for BOOT_CYC rising edges after it is released, the power state output is P2 (2'b10), the status output is 1 and the receive status is 3'b000. The status output is 0 after the BOOT_CYC-th edge.
- R2: Power codes are P0=2'b00, P1=2'b01, P2=2'b10 and P3=2'b11. While the block is idle, a request code that differs from the current state is accepted at a rising edge. The state output takes the new code exactly L edges later, and the status output is 1 in that same cycle.
- R3: L is LAT_P0, LAT_P1, LAT_P2 or LAT_P3, chosen by the target state. When the current state is P3, L is LAT_P3X whatever the target.
- R4: Outside start-up, every status pulse lasts exactly one cycle.
- R5: The request code is sampled only while idle. A change of the code during a transition alters neither its target nor its timing. A code that still differs when the block returns to idle is accepted at the next edge.
- R6: A detection starts when the block is idle, the state is P1, and both the detect/loopback input and the transmit-idle input are high. It completes DET_CYC edges later with a status pulse, and the state does not change.
- R7: In the pulse cycle that ends a detection, the receive status is 3'b011 if the far-end-present input was high at the completing edge, and 3'b000 otherwise. At all other times it is 3'b000.
- R8: A detect request in P0, P2 or P3, or in P1 with the transmit-idle input low, starts nothing and produces no status pulse.
- R9: When a power change and a detection are both requested at the same idle edge, the power change is carried out and no detection runs.
- R10: The transmitter idle output is 1 in P1, P2 and P3. In P0 it follows the transmit-idle input.
- R11: The loopback output is 1 only in P0 with the detect/loopback input high and the transmit-idle input low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_req_i | input | 2 | Requested power state code |
| det_lpbk_i | input | 1 | Detection request (P1) or loopback request (P0) |
| tx_idle_i | input | 1 | Transmit electrical-idle request |
| far_rx_i | input | 1 | Stand-in for the analog far-end termination sense |
| pwr_state_o | output | 2 | Current power state code |
| phy_stat_o | output | 1 | Completion strobe, high through start-up |
| rx_stat_o | output | 3 | Receive status code |
| tx_idle_o | output | 1 | Transmitter electrical-idle control |
| lpbk_o | output | 1 | Loopback enable |

## Verification
The bench builds the block with BOOT_CYC=5, DET_CYC=7, LAT_P0=1, LAT_P1=3, LAT_P2=4, LAT_P3=5 and LAT_P3X=9. Every latency is then distinct, so a pulse at the wrong edge or with the wrong table entry shows up as a miss. The single-edge P0 latency exercises the shortest path, where acceptance is followed at once by completion. The short counts let a random walk over all state pairs, together with detection attempts in every state, run hundreds of operations.

// File: rtl/pipe_pwr_pkg.sv
package pipe_pwr_pkg;
  typedef enum logic [1:0] {
    PS_P0 = 2'b00,
    PS_P1 = 2'b01,
    PS_P2 = 2'b10,
    PS_P3 = 2'b11
  } pwr_e;

  typedef enum logic [1:0] {
    M_BOOT,
    M_IDLE,
    M_PWR,
    M_DET
  } mode_e;

  localparam logic [2:0] RXS_NONE = 3'b000;
  localparam logic [2:0] RXS_DET  = 3'b011;
endpackage

// File: rtl/pipe_pwr_lat.sv
module pipe_pwr_lat
  import pipe_pwr_pkg::*;
#(
  parameter int unsigned CW      = 8,
  parameter int unsigned LAT_P0  = 8,
  parameter int unsigned LAT_P1  = 16,
  parameter int unsigned LAT_P2  = 32,
  parameter int unsigned LAT_P3  = 48,
  parameter int unsigned LAT_P3X = 200
) (
  input  pwr_e          cur_i,
  input  pwr_e          tgt_i,
  output logic [CW-1:0] lat_o
);
  always_comb begin
    if (cur_i == PS_P3) lat_o = CW'(LAT_P3X);
    else begin
      unique case (tgt_i)
        PS_P0:   lat_o = CW'(LAT_P0);
        PS_P1:   lat_o = CW'(LAT_P1);
        PS_P2:   lat_o = CW'(LAT_P2);
        default: lat_o = CW'(LAT_P3);
      endcase
    end
  end
endmodule

// File: rtl/pipe_pwr_seq.sv
module pipe_pwr_seq
  import pipe_pwr_pkg::*;
#(
  parameter int unsigned CW       = 8,
  parameter int unsigned BOOT_CYC = 64,
  parameter int unsigned DET_CYC  = 40
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  pwr_e          req_i,
  input  logic          det_req_i,
  input  logic [CW-1:0] lat_i,
  input  logic          far_rx_i,
  output pwr_e          state_o,
  output logic          phy_stat_o,
  output logic [2:0]    rx_stat_o
);
  mode_e         mode_q;
  pwr_e          tgt_q;
  logic [CW-1:0] cnt_q;
  logic          last_w;

  assign last_w = (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= M_BOOT;
      cnt_q      <= CW'(BOOT_CYC);
      state_o    <= PS_P2;
      tgt_q      <= PS_P2;
      phy_stat_o <= 1'b1;
      rx_stat_o  <= RXS_NONE;
    end else begin
      unique case (mode_q)
        M_BOOT: begin
          if (last_w) begin
            mode_q     <= M_IDLE;
            phy_stat_o <= 1'b0;
          end else cnt_q <= cnt_q - CW'(1);
        end
        M_IDLE: begin
          phy_stat_o <= 1'b0;
          rx_stat_o  <= RXS_NONE;
          // power change outranks detection
          if (req_i != state_o) begin
            mode_q <= M_PWR;
            tgt_q  <= req_i;
            cnt_q  <= lat_i;
          end else if (det_req_i && state_o == PS_P1) begin
            mode_q <= M_DET;
            cnt_q  <= CW'(DET_CYC);
          end
        end
        M_PWR: begin
          if (last_w) begin
            state_o    <= tgt_q;
            phy_stat_o <= 1'b1;
            mode_q     <= M_IDLE;
          end else cnt_q <= cnt_q - CW'(1);
        end
        default: begin
          if (last_w) begin
            phy_stat_o <= 1'b1;
            rx_stat_o  <= far_rx_i ? RXS_DET : RXS_NONE;
            mode_q     <= M_IDLE;
          end else cnt_q <= cnt_q - CW'(1);
        end
      endcase
    end
  end

  p_boot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_BOOT) |-> (phy_stat_o && state_o == PS_P2));
  p_move_with_stat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(state_o) |-> phy_stat_o);
  p_one_cycle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phy_stat_o && mode_q != M_BOOT) |=> !phy_stat_o);
  p_det_in_p1_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_DET) |-> (state_o == PS_P1));
  p_rx_code_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_stat_o != RXS_NONE) |-> (phy_stat_o && rx_stat_o == RXS_DET));
endmodule

// File: rtl/pipe_tx_gate.sv
module pipe_tx_gate
  import pipe_pwr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  pwr_e state_i,
  input  logic tx_idle_i,
  input  logic det_lpbk_i,
  output logic tx_idle_o,
  output logic lpbk_o
);
  assign tx_idle_o = (state_i != PS_P0) | tx_idle_i;
  assign lpbk_o    = (state_i == PS_P0) & det_lpbk_i & ~tx_idle_i;

  p_idle_low_pwr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != PS_P0) |-> tx_idle_o);
  p_lpbk_p0_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lpbk_o |-> (state_i == PS_P0 && !tx_idle_o));
endmodule

// File: rtl/pipe_pwr_ctrl.sv
module pipe_pwr_ctrl
  import pipe_pwr_pkg::*;
#(
  parameter int unsigned BOOT_CYC = 64,
  parameter int unsigned DET_CYC  = 40,
  parameter int unsigned LAT_P0   = 8,
  parameter int unsigned LAT_P1   = 16,
  parameter int unsigned LAT_P2   = 32,
  parameter int unsigned LAT_P3   = 48,
  parameter int unsigned LAT_P3X  = 200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] pwr_req_i,
  input  logic       det_lpbk_i,
  input  logic       tx_idle_i,
  input  logic       far_rx_i,
  output logic [1:0] pwr_state_o,
  output logic       phy_stat_o,
  output logic [2:0] rx_stat_o,
  output logic       tx_idle_o,
  output logic       lpbk_o
);
  localparam int unsigned M01 = (LAT_P0 > LAT_P1) ? LAT_P0 : LAT_P1;
  localparam int unsigned M23 = (LAT_P2 > LAT_P3) ? LAT_P2 : LAT_P3;
  localparam int unsigned MLA = (M01 > M23) ? M01 : M23;
  localparam int unsigned MLB = (MLA > LAT_P3X) ? MLA : LAT_P3X;
  localparam int unsigned MBD = (BOOT_CYC > DET_CYC) ? BOOT_CYC : DET_CYC;
  localparam int unsigned MAXC = (MLB > MBD) ? MLB : MBD;
  localparam int unsigned CW = $clog2(MAXC + 1);

  pwr_e          req_w, state_w;
  logic [CW-1:0] lat_w;

  assign req_w       = pwr_e'(pwr_req_i);
  assign pwr_state_o = state_w;

  pipe_pwr_lat #(
    .CW(CW), .LAT_P0(LAT_P0), .LAT_P1(LAT_P1), .LAT_P2(LAT_P2),
    .LAT_P3(LAT_P3), .LAT_P3X(LAT_P3X)
  ) u_lat (
    .cur_i(state_w), .tgt_i(req_w), .lat_o(lat_w)
  );

  pipe_pwr_seq #(.CW(CW), .BOOT_CYC(BOOT_CYC), .DET_CYC(DET_CYC)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_w),
    .det_req_i(det_lpbk_i & tx_idle_i), .lat_i(lat_w), .far_rx_i(far_rx_i),
    .state_o(state_w), .phy_stat_o(phy_stat_o), .rx_stat_o(rx_stat_o)
  );

  pipe_tx_gate u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .state_i(state_w), .tx_idle_i(tx_idle_i),
    .det_lpbk_i(det_lpbk_i), .tx_idle_o(tx_idle_o), .lpbk_o(lpbk_o)
  );
endmodule

// File: tb/tb_pipe_pwr_ctrl.sv
module tb_pipe_pwr_ctrl;
  localparam int BOOT = 5, DET = 7;
  localparam int L0 = 1, L1 = 3, L2 = 4, L3 = 5, L3X = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] req = 2'b10;
  logic det = 1'b0, txi = 1'b0, far = 1'b0;
  logic [1:0] st;
  logic stat, txo, lpb;
  logic [2:0] rxs;
  int errors = 0, checks = 0;
  logic [1:0] cur = 2'b10;

  always #2.5 clk = ~clk;

  pipe_pwr_ctrl #(.BOOT_CYC(BOOT), .DET_CYC(DET), .LAT_P0(L0), .LAT_P1(L1),
    .LAT_P2(L2), .LAT_P3(L3), .LAT_P3X(L3X)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_req_i(req), .det_lpbk_i(det),
    .tx_idle_i(txi), .far_rx_i(far), .pwr_state_o(st), .phy_stat_o(stat),
    .rx_stat_o(rxs), .tx_idle_o(txo), .lpbk_o(lpb));

  function automatic int exp_lat(logic [1:0] c, logic [1:0] t);
    if (c == 2'b11) return L3X;
    case (t)
      2'b00: return L0;
      2'b01: return L1;
      2'b10: return L2;
      default: return L3;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  // drive one request at a negedge, predict and check the outcome
  task automatic run_op(logic [1:0] r, logic d, logic ti, logic f);
    int lat; logic [1:0] nxt; logic [2:0] erx; bit act;
    req = r; det = d; txi = ti; far = f;
    #1;
    chk(txo == ((cur != 2'b00) | ti), "R10 tx idle", txo, (cur != 2'b00) | ti);
    chk(lpb == ((cur == 2'b00) & d & ~ti), "R11 loopback", lpb, (cur == 2'b00) & d & ~ti);
    act = 1; nxt = cur; erx = 3'b000;
    if (r != cur) begin lat = exp_lat(cur, r); nxt = r; end
    else if (d && ti && cur == 2'b01) begin lat = DET; erx = f ? 3'b011 : 3'b000; end
    else act = 0;
    if (act) begin
      step(); det = 1'b0;
      for (int i = 1; i < lat; i++) step();
      chk(stat == 1'b0 && st == cur, "R2/R3/R6 early", {st, stat}, {cur, 1'b0});
      step();
      chk(stat == 1'b1 && st == nxt, "R2/R3/R6 done", {st, stat}, {nxt, 1'b1});
      chk(rxs == erx, "R7 rx status", rxs, erx);
      step();
      chk(stat == 1'b0 && rxs == 3'b000, "R4 pulse width", {rxs, stat}, 0);
      cur = nxt;
    end else begin
      bit seen = 0;
      for (int i = 0; i < DET + 2; i++) begin step(); if (stat) seen = 1; end
      chk(!seen && st == cur, "R8 no op", {st, 1'(seen)}, {cur, 1'b0});
      det = 1'b0;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd11));
    #12;
    chk(st == 2'b10 && stat && rxs == 3'b000, "R1 in reset", {st, stat}, 5);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 1; i < BOOT; i++) step();
    chk(stat == 1'b1 && st == 2'b10, "R1 boot hold", stat, 1);
    step();
    chk(stat == 1'b0 && st == 2'b10, "R1 boot end", stat, 0);

    run_op(2'b00, 0, 0, 0);          // R3 shortest latency
    run_op(2'b01, 0, 1, 0);
    run_op(2'b01, 1, 1, 1);          // R6 R7 detected
    run_op(2'b01, 1, 1, 0);          // R7 absent
    run_op(2'b01, 1, 0, 1);          // R8 tx idle low
    run_op(2'b00, 1, 1, 1);          // R9 power wins
    run_op(2'b00, 1, 1, 0);          // R8 in P0
    run_op(2'b00, 1, 0, 0);          // R11 loopback
    run_op(2'b11, 0, 0, 0);
    run_op(2'b01, 1, 1, 1);          // R3 P3 exit, R8 in P3 bypassed
    run_op(2'b10, 0, 1, 0);
    run_op(2'b10, 1, 1, 0);          // R8 in P2
    run_op(2'b00, 0, 0, 0);

    // R5: code changes mid-transition
    req = 2'b10; step(); req = 2'b11;
    for (int i = 1; i < L2; i++) step();
    chk(st == 2'b00 && !stat, "R5 early", {st, stat}, 0);
    step();
    chk(st == 2'b10 && stat, "R5 first target", {st, stat}, 5);
    for (int i = 0; i < L3; i++) step();
    chk(st == 2'b10 && !stat, "R5 second pending", {st, stat}, 4);
    step();
    chk(st == 2'b11 && stat, "R5 second target", {st, stat}, 7);
    step();
    cur = 2'b11;

    for (int n = 0; n < 150; n++) begin
      logic [1:0] r = ($urandom % 3 == 0) ? 2'($urandom) : cur;
      run_op(r, 1'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule